// File: doc/BRIEF.md
# Zero-Test Skip and XOR-Literal Execute Stage

This block is the execute stage of a small 8-bit accumulator processor. It handles two 16-bit instruction forms. One folds an 8-bit literal into the working register W with an exclusive OR and refreshes the negative and zero flags. The other reads one data-memory byte and, if the byte is zero, cancels whatever instruction the fetch unit has already brought in. Every other encoding passes through as a no-op.

Each instruction cycle takes four clocks, called phases: decode, operand read, process, and write-back. The phase counter is visible on a port so that the fetch side and the data memory can stay in step with it. A skip raises `discard` for a whole number of instruction cycles. That number is one if the cancelled instruction is one word long, and two if the fetch unit flagged it as the first word of a two-word instruction. While `discard` is high, the word presented to the block is treated as a no-op.

The operand address is 12 bits wide. It is built in one of three ways: from the access bank, from a bank register, or as an offset added to an index pointer when the indexed mode is enabled.

Top module: `tsx_exec_unit`

## Requirements
- R1: After the internal reset releases, `phase` starts at 0 and then counts 0, 1, 2, 3, 0, and so on, one step per clock. The values mean decode, read, process and write.
- R2: While reset is applied, and right after it, W is 00h, N and Z are 0, `discard` is 0 and `dmem_rd` is 0. Asserting reset clears a skip that is in progress.
- R3: The word `0000 1010 kkkk kkkk` (upper byte 0Ah) sets W to W XOR k. The new value is written at the end of the write phase, so it is visible from the next phase 0. For example, B5h XOR AFh gives 1Ah.
- R4: After an XOR-literal, N equals bit 7 of the new W, and Z is 1 exactly when the new W is 00h.
- R5: The word `0110 011a ffff ffff` (bits 15:9 = 0110011b) is the zero test. It raises `dmem_rd` during phase 1 only, and it leaves W, N and Z unchanged.
- R6: With a = 0 (bit 8) and indexed mode not in effect, f below 60h reads address 000h+f, and f of 60h or above reads address F00h+f.
- R7: With a = 1, the read address is {bsr[3:0], f}, whatever the state of `ext_en`.
- R8: With `ext_en` = 1, a = 0 and f at or below 5Fh, the read address is (idx_ptr + f) modulo 1000h. For f at or above 60h, the R6 rule applies.
- R9: If the zero test reads 00h and `fetch_dw` is 0 during its write phase, `discard` is 1 for exactly the next instruction cycle (all four phases) and 0 after that.
- R10: If the zero test reads 00h and `fetch_dw` is 1 during its write phase, `discard` is 1 for exactly the next two instruction cycles.
- R11: If the zero test reads a nonzero byte, `discard` stays 0.
- R12: A word presented while `discard` is 1 has no effect. An XOR-literal leaves W and the flags as they are. A zero test issues no read and starts no skip.
- R13: Any encoding that matches neither form is a no-op. It does not change W or the flags, and it issues no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| instr_word | input | 16 | Instruction word, sampled at the end of phase 0 |
| fetch_dw | input | 1 | The word being prefetched starts a two-word instruction; sampled at the end of phase 3 |
| bsr | input | 4 | Bank register, used as the upper address bits when a = 1 |
| ext_en | input | 1 | Enables indexed offset addressing |
| idx_ptr | input | 12 | Index pointer base for indexed addressing |
| dmem_rdata | input | 8 | Read data, valid in the phase after `dmem_rd` |
| dmem_rd | output | 1 | Data-memory read strobe (phase 1 only) |
| dmem_addr | output | 12 | Data-memory read address |
| w_out | output | 8 | Working register W |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| discard | output | 1 | The current instruction cycle is cancelled and runs as a no-op |
| phase | output | 2 | Current phase: 0 decode, 1 read, 2 process, 3 write |

## Verification
On every cycle, the embedded properties check the following:
- the phase counts without gaps;
- W changes only at the boundary between cycles;
- the flags match any new W value;
- a zero test never disturbs W or the flags;
- `discard` changes only at a cycle boundary, rises only after a zero result, and never overlaps a read;
- the skip count never goes above two.

Only the bench scenarios can show the actual numbers. These are the XOR results, the address chosen by each of the three addressing rules (including the wrap of the indexed sum and the 5Fh/60h split), and the exact length of a one-word or two-word skip. They also show that a cancelled zero test leaves no skip behind, and that a reset in the middle of a skip clears it.

// File: rtl/tsx_pkg.sv
`timescale 1ns/1ps
package tsx_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    PH_DEC  = 2'd0,
    PH_RD   = 2'd1,
    PH_PROC = 2'd2,
    PH_WR   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_XORL = 2'd1,
    OP_TSTZ = 2'd2
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              acc_sel;
    logic [DATA_W-1:0] lit;
  } ir_t;

  localparam logic [7:0] XORL_PFX = 8'h0A;
  localparam logic [6:0] TSTZ_PFX = 7'b0110011;

  function automatic op_e decode_op(input logic [WORD_W-1:0] w);
    if (w[15:8] == XORL_PFX) begin
      return OP_XORL;
    end else if (w[15:9] == TSTZ_PFX) begin
      return OP_TSTZ;
    end
    return OP_NOP;
  endfunction
endpackage

// File: rtl/tsx_phase_seq.sv
`timescale 1ns/1ps
module tsx_phase_seq
  import tsx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_ni,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_e'(phase_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_DEC;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R1: one phase step per clock once running
  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(rst_ni) |-> (phase_q == phase_e'($past(phase_q) + 2'd1)));
endmodule

// File: rtl/tsx_decode.sv
`timescale 1ns/1ps
module tsx_decode
  import tsx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic              squash_i,
  output ir_t               ir_o
);
  ir_t  ir_q, ir_d;
  logic ld_en;

  always_comb begin
    ld_en      = (phase_i == PH_DEC);
    ir_d.op    = squash_i ? OP_NOP : decode_op(instr_i);
    ir_d.acc_sel = instr_i[8];
    ir_d.lit   = instr_i[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    ir_q <= '0;
    else if (ld_en) ir_q <= ir_d;
  end

  assign ir_o = ir_q;

  // R12: a word taken during a cancelled cycle holds no operation
  p_squash_nop_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_i == PH_RD && $past(squash_i)) |-> (ir_q.op == OP_NOP));
endmodule

// File: rtl/tsx_addr_gen.sv
`timescale 1ns/1ps
module tsx_addr_gen #(
  parameter int unsigned BANK_W      = 4,
  parameter int unsigned OFS_W       = 8,
  parameter logic [OFS_W-1:0] ACC_SPLIT = 8'h60,
  parameter bit          HAS_INDEXED = 1'b1,
  localparam int unsigned ADDR_W     = BANK_W + OFS_W
) (
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              acc_sel_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              idx_en_i,
  input  logic [ADDR_W-1:0] idx_base_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] direct_ea;

  always_comb begin
    if (acc_sel_i) begin
      direct_ea = {bank_i, ofs_i};
    end else if (ofs_i < ACC_SPLIT) begin
      direct_ea = {{BANK_W{1'b0}}, ofs_i};
    end else begin
      direct_ea = {{BANK_W{1'b1}}, ofs_i};
    end
  end

  generate
    if (HAS_INDEXED) begin : g_idx
      logic use_idx;
      always_comb begin
        use_idx = idx_en_i && !acc_sel_i && (ofs_i < ACC_SPLIT);
        ea_o    = use_idx ? (idx_base_i + {{BANK_W{1'b0}}, ofs_i}) : direct_ea;
      end
    end else begin : g_noidx
      always_comb begin
        ea_o = direct_ea;
      end
    end
  endgenerate
endmodule

// File: rtl/tsx_skip_ctl.sv
`timescale 1ns/1ps
module tsx_skip_ctl
  import tsx_pkg::*;
#(
  parameter int unsigned MAX_SKIP = 2,
  localparam int unsigned CNT_W   = $clog2(MAX_SKIP + 1)
) (
  input  logic   clk,
  input  logic   rst_ni,
  input  phase_e phase_i,
  input  logic   is_test_i,
  input  logic   opnd_zero_i,
  input  logic   two_word_i,
  output logic   discard_o
);
  logic             zero_q, zero_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    zero_d = zero_q;
    if (phase_i == PH_PROC) zero_d = is_test_i && opnd_zero_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (phase_i == PH_WR) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (is_test_i && zero_q) begin
        cnt_d = two_word_i ? CNT_W'(MAX_SKIP) : CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      zero_q <= zero_d;
      cnt_q  <= cnt_d;
    end
  end

  assign discard_o = (cnt_q != '0);

  // R9: the cancel window opens and closes only at cycle boundaries
  p_disc_edge_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_i != PH_DEC) |-> $stable(discard_o));
  // R11: a window opens only after a zero-valued test
  p_skip_cause_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(discard_o) |-> $past(is_test_i && zero_q));
  // R10: a skip covers at most two words
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_SKIP));
  // R10: a two-word flag at the start of a skip gives the long window
  p_two_word_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(discard_o) && $past(two_word_i)) |-> (cnt_q == CNT_W'(MAX_SKIP)));
endmodule

// File: rtl/tsx_exec_unit.sv
`timescale 1ns/1ps
module tsx_exec_unit
  import tsx_pkg::*;
#(
  parameter int unsigned BANK_W      = 4,
  parameter bit          HAS_INDEXED = 1'b1,
  localparam int unsigned ADDR_W     = BANK_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] instr_word,
  input  logic              fetch_dw,
  input  logic [BANK_W-1:0] bsr,
  input  logic              ext_en,
  input  logic [ADDR_W-1:0] idx_ptr,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic              dmem_rd,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] w_out,
  output logic              flag_n,
  output logic              flag_z,
  output logic              discard,
  output logic [1:0]        phase
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  phase_e            ph;
  ir_t               ir;
  logic [ADDR_W-1:0] ea;
  logic              skip_now;

  tsx_phase_seq u_phase (
    .clk     (clk),
    .rst_ni  (rst_core_n),
    .phase_o (ph)
  );

  tsx_decode u_dec (
    .clk      (clk),
    .rst_ni   (rst_core_n),
    .phase_i  (ph),
    .instr_i  (instr_word),
    .squash_i (skip_now),
    .ir_o     (ir)
  );

  tsx_addr_gen #(
    .BANK_W      (BANK_W),
    .OFS_W       (DATA_W),
    .ACC_SPLIT   (8'h60),
    .HAS_INDEXED (HAS_INDEXED)
  ) u_agen (
    .ofs_i      (ir.lit),
    .acc_sel_i  (ir.acc_sel),
    .bank_i     (bsr),
    .idx_en_i   (ext_en),
    .idx_base_i (idx_ptr),
    .ea_o       (ea)
  );

  tsx_skip_ctl #(.MAX_SKIP(2)) u_skip (
    .clk         (clk),
    .rst_ni      (rst_core_n),
    .phase_i     (ph),
    .is_test_i   (ir.op == OP_TSTZ),
    .opnd_zero_i (dmem_rdata == '0),
    .two_word_i  (fetch_dw),
    .discard_o   (skip_now)
  );

  // datapath: result formed in process phase, committed in write phase
  logic [DATA_W-1:0] res_q, res_d, w_q, w_d;
  logic              n_q, n_d, z_q, z_d;

  always_comb begin
    res_d = res_q;
    if (ph == PH_PROC) res_d = w_q ^ ir.lit;
  end

  always_comb begin
    w_d = w_q;
    n_d = n_q;
    z_d = z_q;
    if (ph == PH_WR && ir.op == OP_XORL) begin
      w_d = res_q;
      n_d = res_q[DATA_W-1];
      z_d = (res_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      res_q <= '0;
      w_q   <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
    end else begin
      res_q <= res_d;
      w_q   <= w_d;
      n_q   <= n_d;
      z_q   <= z_d;
    end
  end

  assign dmem_rd   = (ph == PH_RD) && (ir.op == OP_TSTZ);
  assign dmem_addr = ea;
  assign w_out     = w_q;
  assign flag_n    = n_q;
  assign flag_z    = z_q;
  assign discard   = skip_now;
  assign phase     = ph;

  // R3: W moves only across a cycle boundary
  p_w_hold_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ph != PH_DEC) |-> $stable(w_q));
  // R4: flags agree with any freshly written W
  p_flags_follow_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(w_q) |-> ((z_q == (w_q == '0)) && (n_q == w_q[DATA_W-1])));
  // R5: a zero test leaves W and flags untouched
  p_test_keeps_state_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ph == PH_DEC && $past(ir.op) == OP_TSTZ) |-> $stable({w_q, n_q, z_q}));
  // R12: no read while the cycle is cancelled
  p_no_read_in_skip_r12: assert property (@(posedge clk) disable iff (!rst_core_n)
    skip_now |-> !dmem_rd);
endmodule

// File: tb/tb_tsx_exec_unit.sv
`timescale 1ns/1ps
module tb_tsx_exec_unit;
  logic        clk;
  logic        rst_n;
  logic [15:0] instr_word;
  logic        fetch_dw;
  logic [3:0]  bsr;
  logic        ext_en;
  logic [11:0] idx_ptr;
  logic [7:0]  dmem_rdata;
  logic        dmem_rd;
  logic [11:0] dmem_addr;
  logic [7:0]  w_out;
  logic        flag_n;
  logic        flag_z;
  logic        discard;
  logic [1:0]  phase;

  int n_chk;
  int n_bad;
  logic [11:0] zaddr;

  tsx_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .fetch_dw(fetch_dw),
    .bsr(bsr), .ext_en(ext_en), .idx_ptr(idx_ptr), .dmem_rdata(dmem_rdata),
    .dmem_rd(dmem_rd), .dmem_addr(dmem_addr), .w_out(w_out), .flag_n(flag_n),
    .flag_z(flag_z), .discard(discard), .phase(phase)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // data memory model: one-cycle read latency, zero only at zaddr
  always @(posedge clk) begin
    if (dmem_rd) dmem_rdata <= (dmem_addr == zaddr) ? 8'h00 : 8'h3C;
  end

  typedef struct packed {
    logic [15:0] word;
    logic        dw;
    logic [3:0]  bk;
    logic        ext;
    logic [11:0] idx;
    logic [11:0] za;
    logic [7:0]  w;
    logic        n;
    logic        z;
    logic        rd;
    logic [11:0] addr;
    logic        disc;
  } vec_t;

  localparam int NV = 24;
  // word, dw, bsr, ext, idx, zero-addr | exp W, N, Z, read, addr, discard-in-cycle
  localparam vec_t VECS [NV] = '{
    '{16'h0AB5, 1'b0, 4'h0, 1'b0, 12'h000, 12'hFFF, 8'hB5, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0}, // R3 R4
    '{16'h0AAF, 1'b0, 4'h0, 1'b0, 12'h000, 12'hFFF, 8'h1A, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0}, // R3
    '{16'h0A1A, 1'b0, 4'h0, 1'b0, 12'h000, 12'hFFF, 8'h00, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0}, // R4
    '{16'h0A80, 1'b0, 4'h0, 1'b0, 12'h000, 12'hFFF, 8'h80, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0}, // R4
    '{16'h6625, 1'b0, 4'h3, 1'b0, 12'h000, 12'hFFF, 8'h80, 1'b1, 1'b0, 1'b1, 12'h025, 1'b0}, // R5 R6 R11
    '{16'h669C, 1'b0, 4'h3, 1'b0, 12'h000, 12'hFFF, 8'h80, 1'b1, 1'b0, 1'b1, 12'hF9C, 1'b0}, // R6
    '{16'h6740, 1'b0, 4'h7, 1'b0, 12'h000, 12'hFFF, 8'h80, 1'b1, 1'b0, 1'b1, 12'h740, 1'b0}, // R7
    '{16'h6610, 1'b0, 4'h7, 1'b1, 12'h200, 12'hFFF, 8'h80, 1'b1, 1'b0, 1'b1, 12'h210, 1'b0}, // R8
    '{16'h665F, 1'b0, 4'h7, 1'b1, 12'hFF0, 12'hFFF, 8'h80, 1'b1, 1'b0, 1'b1, 12'h04F, 1'b0}, // R8 wrap
    '{16'h6660, 1'b0, 4'h7, 1'b1, 12'hFF0, 12'hFFF, 8'h80, 1'b1, 1'b0, 1'b1, 12'hF60, 1'b0}, // R8 split
    '{16'h6710, 1'b0, 4'h5, 1'b1, 12'h200, 12'hFFF, 8'h80, 1'b1, 1'b0, 1'b1, 12'h510, 1'b0}, // R7
    '{16'h6633, 1'b0, 4'h5, 1'b0, 12'h000, 12'h033, 8'h80, 1'b1, 1'b0, 1'b1, 12'h033, 1'b0}, // R9
    '{16'h0AFF, 1'b0, 4'h5, 1'b0, 12'h000, 12'h033, 8'h80, 1'b1, 1'b0, 1'b0, 12'h000, 1'b1}, // R9 R12
    '{16'h0A01, 1'b0, 4'h5, 1'b0, 12'h000, 12'h033, 8'h81, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0}, // R9
    '{16'h6744, 1'b1, 4'h1, 1'b0, 12'h000, 12'h144, 8'h81, 1'b1, 1'b0, 1'b1, 12'h144, 1'b0}, // R10
    '{16'h0A0F, 1'b0, 4'h1, 1'b0, 12'h000, 12'h144, 8'h81, 1'b1, 1'b0, 1'b0, 12'h000, 1'b1}, // R10 R12
    '{16'h6601, 1'b0, 4'h1, 1'b0, 12'h000, 12'h001, 8'h81, 1'b1, 1'b0, 1'b0, 12'h000, 1'b1}, // R10 R12
    '{16'h0A81, 1'b0, 4'h1, 1'b0, 12'h000, 12'h001, 8'h00, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0}, // R10
    '{16'h1234, 1'b0, 4'h1, 1'b0, 12'h000, 12'hFFF, 8'h00, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0}, // R13
    '{16'h0B01, 1'b0, 4'h1, 1'b0, 12'h000, 12'hFFF, 8'h00, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0}, // R13
    '{16'h6E55, 1'b0, 4'h1, 1'b0, 12'h000, 12'h055, 8'h00, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0}, // R13
    '{16'h6655, 1'b0, 4'h1, 1'b0, 12'h000, 12'h055, 8'h00, 1'b0, 1'b1, 1'b1, 12'h055, 1'b0}, // R5 R9
    '{16'h6655, 1'b0, 4'h1, 1'b0, 12'h000, 12'h055, 8'h00, 1'b0, 1'b1, 1'b0, 12'h000, 1'b1}, // R12
    '{16'h0A00, 1'b0, 4'h1, 1'b0, 12'h000, 12'h055, 8'h00, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0}  // R12
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a falling edge in phase 0; returns at phase 0 of the next cycle
  task automatic run_vec(input vec_t v, input int k);
    bit          ph_ok;
    bit          rd_seen;
    bit          rd_stray;
    bit          disc_seen;
    logic [11:0] addr_seen;
    instr_word = v.word;
    fetch_dw   = v.dw;
    bsr        = v.bk;
    ext_en     = v.ext;
    idx_ptr    = v.idx;
    zaddr      = v.za;
    ph_ok = 1'b1; rd_seen = 1'b0; rd_stray = 1'b0; disc_seen = 1'b0; addr_seen = '0;
    for (int p = 0; p < 4; p++) begin
      if (phase != 2'(p)) ph_ok = 1'b0;
      if (p == 0) disc_seen = discard;
      if (p == 1) begin
        rd_seen   = dmem_rd;
        addr_seen = dmem_addr;
      end else if (dmem_rd) begin
        rd_stray = 1'b1;
      end
      @(negedge clk);
    end
    chk(ph_ok, "R1", $sformatf("vec %0d phase order", k), 0, 0);
    chk(w_out == v.w, "R3/R12/R13", $sformatf("vec %0d W", k), w_out, v.w);
    chk({flag_n, flag_z} == {v.n, v.z}, "R4/R5", $sformatf("vec %0d N,Z", k),
        {flag_n, flag_z}, {v.n, v.z});
    chk(rd_seen == v.rd && !rd_stray, "R5/R12/R13", $sformatf("vec %0d read", k),
        {rd_stray, rd_seen}, v.rd);
    if (v.rd) chk(addr_seen == v.addr, "R6/R7/R8", $sformatf("vec %0d address", k),
                  addr_seen, v.addr);
    chk(disc_seen == v.disc, "R9/R10/R11", $sformatf("vec %0d discard", k),
        disc_seen, v.disc);
  endtask

  task automatic align_after_reset();
    do @(negedge clk); while (phase != 2'd3);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; instr_word = 16'h0000; fetch_dw = 1'b0; bsr = 4'h0;
    ext_en = 1'b0; idx_ptr = 12'h000; dmem_rdata = 8'h00; zaddr = 12'hFFF;
    repeat (3) @(negedge clk);
    // R2: state while held in reset
    chk(w_out == 8'h00 && !flag_n && !flag_z, "R2", "W/flags in reset", {w_out, flag_n, flag_z}, 0);
    chk(!discard && !dmem_rd, "R2", "discard/read in reset", {discard, dmem_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phase == 2'd0, "R1", "phase held at 0 right after release", phase, 0);
    align_after_reset();
    chk(w_out == 8'h00 && !discard, "R2", "state after release", {w_out, discard}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R2: reset during a two-word skip clears it
    run_vec('{16'h0A5A, 1'b0, 4'h2, 1'b0, 12'h000, 12'h2AA, 8'h5A, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0}, 100);
    run_vec('{16'h67AA, 1'b1, 4'h2, 1'b0, 12'h000, 12'h2AA, 8'h5A, 1'b0, 1'b0, 1'b1, 12'h2AA, 1'b0}, 101);
    chk(discard == 1'b1, "R10", "skip active before reset", discard, 1);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk(!discard && w_out == 8'h00, "R2", "async clear of skip and W", {discard, w_out}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    instr_word = 16'h0000;
    align_after_reset();
    chk(!discard && !flag_n && !flag_z, "R2", "no skip after reset", {discard, flag_n, flag_z}, 0);
    // R11: nonzero test after reset leaves discard low; R3 resumes
    run_vec('{16'h6611, 1'b1, 4'h0, 1'b0, 12'h000, 12'h0FF, 8'h00, 1'b0, 1'b0, 1'b1, 12'h011, 1'b0}, 102);
    run_vec('{16'h0AC3, 1'b0, 4'h0, 1'b0, 12'h000, 12'h0FF, 8'hC3, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0}, 103);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule